// File: doc/BRIEF.md
# Routed SPI Control Slave

This block is the serial control front end of a four-channel RF synthesizer board. A host drives a mode-0 SPI link: chip select active high, clock idling low, data sampled on the rising clock edge, most significant bit first. Every frame opens with an 8-bit prefix, made of a 7-bit address followed by a write-enable bit. The address selects one of three frame formats.

Addresses below 8 reach a small internal bank of 16-bit registers through 24-bit frames. These frames can write a register or read it back on MISO. Register 0 is a read-only identity word. Register 1 holds the reference clock select and the global mezzanine output enable. Addresses 8 to 11 carry an 8-bit step-attenuator code for channels 0 to 3. The code is kept locally and announced with a load strobe. Addresses 12 to 15 open a pass-through to one of four mezzanine shift registers. Every bit after the prefix is replayed on a dedicated chip select, clock and data line.

All SPI inputs are brought into the system clock domain through two-flop synchronizers. The serial clock edges are detected on the synchronized copy, so the system clock must run several times faster than the serial clock.

Top module: `spi_route_slave`

## Requirements
- R1: After reset, spi_miso, mez_cs, att_load, att_code, clk_sel and mez_oe are all zero.
- R2: Frames are shifted MSB first on rising serial clock edges while spi_cs is high. Bits 0..6 of the frame are the address (first bit is address MSB) and bit 7 is the write-enable.
- R3: A 24-bit frame to address 1 with write-enable 1 stores its last 16 bits when chip select falls. clk_sel then shows stored bits [5:4] and mez_oe shows stored bit 12.
- R4: A 24-bit frame to an address below 8 with write-enable 0 returns that register's 16-bit value on spi_miso, MSB first, one bit per clock, in frame bits 8..23. Register 1 reads back the full word last written.
- R5: Register 0 reads as hw_rev in bits [1:0], protocol revision 0 in bits [3:2], and zero above. Writes to register 0 change nothing.
- R6: Addresses 2 to 7 read as zero, and writes to them leave register 1 unchanged.
- R7: A write frame whose length is not exactly 24 bits is discarded.
- R8: A frame of exactly 16 bits to address 8+n stores its last 8 bits in att_code[8n+7:8n] when chip select falls. att_load[n] then pulses for one clock, and the other channels are unchanged. A frame of any other length is discarded.
- R9: A frame to address 12+n raises mez_cs[n] after the 8-bit prefix and holds it until chip select falls. mez_sck and mez_sdo replay every following bit. No mez_cs bit rises for any other address.
- R10: spi_miso is low outside the data phase of a read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_cs | input | 1 | Frame select from host, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial read data to host |
| hw_rev | input | 2 | Board revision code reported in register 0 |
| clk_sel | output | 2 | Reference clock select, register 1 bits [5:4] |
| mez_oe | output | 1 | Mezzanine output enable, register 1 bit 12 |
| att_code | output | 32 | Stored attenuator codes, channel n at [8n+7:8n] |
| att_load | output | 4 | One-clock load strobe per attenuator channel |
| mez_cs | output | 4 | Pass-through chip select per mezzanine channel |
| mez_sck | output | 1 | Pass-through serial clock |
| mez_sdo | output | 1 | Pass-through serial data |

## Verification
Register 1 is written and read back with all-zeros, all-ones, alternating and single-bit words. These patterns expose stuck bits, swapped bit order and a misplaced clock-select or output-enable field. Distinct codes are sent to each attenuator channel, and distinct bit counts go to two mezzanine channels. Together these separate a wrong channel decode from a wrong payload slice. Frames that are one bit too long or too short, and writes to register 0 and to unused addresses, show that only exactly framed accesses to the right place take effect.

// File: rtl/spi_route_slave.sv
module spi_route_slave #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int CODE_W = 8,
  parameter int N_CH = 4,
  parameter int ATT_BASE = 8,
  parameter int MEZ_BASE = 12,
  parameter int CNT_W = 6,
  parameter logic [1:0] PROTO_REV = 2'b00
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_sck,
  input  logic                     spi_cs,
  input  logic                     spi_mosi,
  output logic                     spi_miso,
  input  logic [1:0]               hw_rev,
  output logic [1:0]               clk_sel,
  output logic                     mez_oe,
  output logic [N_CH*CODE_W-1:0]   att_code,
  output logic [N_CH-1:0]          att_load,
  output logic [N_CH-1:0]          mez_cs,
  output logic                     mez_sck,
  output logic                     mez_sdo
);
  localparam int HDR_W = ADDR_W + 1;
  localparam int REG_FRAME = HDR_W + DATA_W;
  localparam int ATT_FRAME = HDR_W + CODE_W;
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int CSEL_LSB = 4;
  localparam int OE_BIT = 12;

  logic sck_m, sck_s, sck_d, cs_m, cs_s, cs_d, mosi_m, mosi_s;
  logic [CNT_W-1:0] cnt;
  logic [REG_FRAME-1:0] shreg;
  logic [ADDR_W-1:0] hdr_addr;
  logic hdr_we;
  logic [DATA_W-1:0] rd_word, rd_sel, ctrl;
  logic rd_act, pass_on;
  logic [CODE_W-1:0] att_q [N_CH];

  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire cs_fall  = ~cs_s & cs_d;
  wire [HDR_W-1:0]  hdr_next = {shreg[HDR_W-2:0], mosi_s};
  wire [ADDR_W-1:0] nxt_addr = hdr_next[HDR_W-1:1];
  wire is_att = (hdr_addr >= ADDR_W'(ATT_BASE)) && (hdr_addr < ADDR_W'(ATT_BASE + N_CH));
  wire is_mez = (hdr_addr >= ADDR_W'(MEZ_BASE)) && (hdr_addr < ADDR_W'(MEZ_BASE + N_CH));
  wire [CH_W-1:0] att_ch = CH_W'(hdr_addr - ADDR_W'(ATT_BASE));
  wire [CH_W-1:0] mez_ch = CH_W'(hdr_addr - ADDR_W'(MEZ_BASE));

  always_comb begin
    case (nxt_addr)
      ADDR_W'(0): rd_sel = {{(DATA_W-4){1'b0}}, PROTO_REV, hw_rev};
      ADDR_W'(1): rd_sel = ctrl;
      default:    rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sck_m, sck_s, sck_d, cs_m, cs_s, cs_d, mosi_m, mosi_s} <= '0;
      cnt <= '0; shreg <= '0; hdr_addr <= '0; hdr_we <= 1'b0;
      rd_word <= '0; rd_act <= 1'b0; pass_on <= 1'b0;
      ctrl <= '0; att_load <= '0;
      for (int i = 0; i < N_CH; i++) att_q[i] <= '0;
    end else begin
      sck_m <= spi_sck;   sck_s <= sck_m;   sck_d <= sck_s;
      cs_m <= spi_cs;     cs_s <= cs_m;     cs_d <= cs_s;
      mosi_m <= spi_mosi; mosi_s <= mosi_m;
      att_load <= '0;
      if (!cs_s) begin
        cnt <= '0; rd_act <= 1'b0; pass_on <= 1'b0;
      end else begin
        if (sck_rise) begin
          shreg <= {shreg[REG_FRAME-2:0], mosi_s};
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(HDR_W-1)) begin
            hdr_addr <= nxt_addr;
            hdr_we   <= hdr_next[0];
            rd_word  <= rd_sel;
            rd_act   <= (nxt_addr < ADDR_W'(ATT_BASE)) && !hdr_next[0];
          end else if (rd_act) begin
            rd_word <= {rd_word[DATA_W-2:0], 1'b0};
            if (cnt == CNT_W'(REG_FRAME-1)) rd_act <= 1'b0;
          end
        end
        if (sck_fall && cnt == CNT_W'(HDR_W) && is_mez) pass_on <= 1'b1;
      end
      if (cs_fall) begin
        if (hdr_we && hdr_addr == ADDR_W'(1) && cnt == CNT_W'(REG_FRAME))
          ctrl <= shreg[DATA_W-1:0];
        if (is_att && cnt == CNT_W'(ATT_FRAME)) begin
          att_q[att_ch]    <= shreg[CODE_W-1:0];
          att_load[att_ch] <= 1'b1;
        end
      end
    end
  end

  assign spi_miso = rd_act & rd_word[DATA_W-1];
  assign clk_sel  = ctrl[CSEL_LSB+1:CSEL_LSB];
  assign mez_oe   = ctrl[OE_BIT];
  assign mez_sck  = pass_on & sck_s;
  assign mez_sdo  = pass_on & mosi_s;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign att_code[g*CODE_W +: CODE_W] = att_q[g];
    assign mez_cs[g] = pass_on && (mez_ch == CH_W'(g));
  end

  a_r3_ctrl_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl) |-> $past(cs_fall));
  a_r8_code_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    (att_code != $past(att_code)) |-> (|att_load));
  a_r8_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(att_load));
  a_r8_load_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (|att_load) |-> !cs_s);
  a_r9_one_mez_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mez_cs));
  a_r9_mez_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (|mez_cs) |-> $past(cs_s));
  a_r10_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !$past(cs_s)) |-> !spi_miso);
endmodule

// File: tb/spi_route_slave_tb_top.sv
module spi_route_slave_tb_top;
  localparam int HALF = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs = 1'b0, mosi = 1'b0;
  logic [1:0] hw_rev = 2'b10;
  logic miso, mez_oe, mez_sck, mez_sdo;
  logic [1:0] clk_sel;
  logic [31:0] att_code;
  logic [3:0] att_load, mez_cs;
  int checks = 0, failures = 0;
  logic [63:0] rx, mez_bits;
  int mez_n = 0;
  logic [3:0] seen = '0;
  int lcnt [4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  spi_route_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs(cs), .spi_mosi(mosi),
    .spi_miso(miso), .hw_rev(hw_rev), .clk_sel(clk_sel), .mez_oe(mez_oe),
    .att_code(att_code), .att_load(att_load), .mez_cs(mez_cs),
    .mez_sck(mez_sck), .mez_sdo(mez_sdo));

  always @(posedge mez_sck) begin
    mez_bits = {mez_bits[62:0], mez_sdo};
    mez_n = mez_n + 1;
  end

  always @(negedge clk) begin
    seen = seen | mez_cs;
    for (int i = 0; i < 4; i++) if (att_load[i]) lcnt[i] = lcnt[i] + 1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [63:0] d, input int n);
    rx = '0;
    @(negedge clk) cs = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = d[i];
      repeat (HALF) @(negedge clk);
      rx = {rx[62:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs = 1'b0; mosi = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    xfer({40'd0, a, 1'b1, d}, 24);
  endtask

  task automatic rd(input logic [6:0] a);
    xfer({40'd0, a, 1'b0, 16'd0}, 24);
  endtask

  task automatic clr_mon();
    seen = '0; mez_n = 0; mez_bits = '0;
    for (int i = 0; i < 4; i++) lcnt[i] = 0;
  endtask

  localparam logic [15:0] WVEC [6] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h1030, 16'h0020};

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 miso", miso, 0);
    chk("R1 mez_cs", mez_cs, 0);
    chk("R1 att_load", att_load, 0);
    chk("R1 att_code", att_code, 0);
    chk("R1 clk_sel", clk_sel, 0);
    chk("R1 mez_oe", mez_oe, 0);

    foreach (WVEC[k]) begin
      wr(7'd1, WVEC[k]);
      chk("R3 clk_sel", clk_sel, WVEC[k][5:4]);
      chk("R3 mez_oe", mez_oe, WVEC[k][12]);
      rd(7'd1);
      chk("R4 readback", rx[15:0], WVEC[k]);
      chk("R10 miso idle in prefix", rx[23:16], 0);
    end

    wr(7'd1, 16'h0010);
    chk("R2 msb-first field", clk_sel, 2'b01);

    rd(7'd0);
    chk("R5 id word", rx[15:0], 16'h0002);
    wr(7'd0, 16'hFFFF);
    rd(7'd0);
    chk("R5 id after write", rx[15:0], 16'h0002);
    chk("R5 clk_sel kept", clk_sel, 2'b01);

    wr(7'd5, 16'hFFFF);
    rd(7'd1);
    chk("R6 reg1 kept", rx[15:0], 16'h0010);
    rd(7'd5);
    chk("R6 unused reads zero", rx[15:0], 16'h0000);

    xfer({39'd0, 7'd1, 1'b1, 16'h1030, 1'b0}, 25);
    rd(7'd1);
    chk("R7 long write dropped", rx[15:0], 16'h0010);
    xfer({41'd0, 7'd1, 1'b1, 15'h7FFF}, 23);
    rd(7'd1);
    chk("R7 short write dropped", rx[15:0], 16'h0010);
    chk("R10 miso low after read", miso, 0);

    clr_mon();
    xfer({48'd0, 7'd8,  1'b0, 8'h11}, 16);
    xfer({48'd0, 7'd9,  1'b0, 8'h82}, 16);
    xfer({48'd0, 7'd10, 1'b0, 8'hFF}, 16);
    xfer({48'd0, 7'd11, 1'b0, 8'h3C}, 16);
    chk("R8 codes", att_code, 32'h3CFF8211);
    for (int i = 0; i < 4; i++) chk("R8 one load per channel", lcnt[i], 1);
    chk("R9 no mez_cs on attenuator frames", seen, 0);
    clr_mon();
    xfer({40'd0, 7'd9, 1'b0, 16'h5500}, 24);
    chk("R8 wrong length dropped", att_code, 32'h3CFF8211);
    chk("R8 no load on wrong length", lcnt[1], 0);

    clr_mon();
    xfer({44'd0, 7'd13, 1'b0, 12'hABC}, 20);
    chk("R9 ch1 select", seen, 4'b0010);
    chk("R9 ch1 bit count", mez_n, 12);
    chk("R9 ch1 payload", mez_bits[11:0], 12'hABC);
    chk("R9 cs released", mez_cs, 0);
    clr_mon();
    xfer({48'd0, 7'd15, 1'b1, 8'h96}, 16);
    chk("R9 ch3 select", seen, 4'b1000);
    chk("R9 ch3 bit count", mez_n, 8);
    chk("R9 ch3 payload", mez_bits[7:0], 8'h96);
    chk("R9 attenuators untouched", att_code, 32'h3CFF8211);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule